// File: doc/BRIEF.md
# Operation-Timed ALU Completion Wrapper

This block puts a combinational ALU behind a four-phase request/acknowledge handshake and produces the acknowledge itself. The ALU has no completion signal of its own. The wrapper therefore waits for a time matched to the operation in progress and then raises acknowledge. The wait is counted in ticks of a fast reference clock, and each tick stands for one unit delay element. Cheap logic operations complete after a few units. Multiply and divide hold the requester for much longer.

Each operation class has its own critical-path figure in picoseconds, held as a parameter. A safety margin, given as a percentage, is added to that figure. The sum is divided by the unit delay and rounded up to give that class's unit count. The operation code and operands are latched when a request is first seen. Later changes on those inputs are ignored until the handshake returns to idle. If a requester withdraws its request before acknowledge has risen, the wrapper reports a one-cycle protocol-error pulse and abandons the operation.

Top module: `alu_mdw`

## Requirements
- R1: While reset is low and after its release, `ack` and `proto_err` are 0 and `result` is 0.
- R2: The unit count of each class is ceil(T × (100 + MARGIN_PCT) / (100 × UNIT_PS)), with a minimum of 1. The defaults are UNIT_PS=100, MARGIN_PCT=50 and T of 1200/1300/300/300/400/6000/9000 ps. These give add 18, sub 20, and 5, or 5, xor 6, mul 90 and div 135 units.
- R3: Opcode encoding is 0 add, 1 sub, 2 and, 3 or, 4 xor, 5 mul, 6 div. A clock edge that sees `req` high while idle starts an operation. `ack` becomes 1 after exactly N further rising edges, where N is the opcode's unit count.
- R4: Opcode 7 is unrecognised. It waits the longest count in the table (135 by default) and yields result 0.
- R5: `result` is a+b and a−b modulo 2^W, a&b, a|b, a^b, the low W bits of a×b, and a/b truncated. Division by zero gives all ones.
- R6: `op`, `a` and `b` are latched at the starting edge. Changes to them before the handshake returns to idle have no effect on `result` or on the delay.
- R7: `result` holds its final value from before `ack` rises until after `ack` falls.
- R8: Once `ack` is high, it falls at the first edge that sees `req` low. The block is then idle and ready for a new request.
- R9: If `req` is low at an edge while an operation is timing, `proto_err` is 1 for exactly one cycle and `ack` stays 0. This includes the edge on which the count would have expired. The block then returns to idle.
- R10: `ack` is never 1 unless `req` was high at the preceding edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference tick clock, one period per unit delay |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Four-phase request from the controller |
| op | input | 3 | Operation code |
| a | input | W | First operand |
| b | input | W | Second operand |
| result | output | W | ALU result for the latched operation |
| ack | output | 1 | Completion acknowledge |
| proto_err | output | 1 | One-cycle pulse on early request withdrawal |

## Verification
Delay expiry and request withdrawal can land on the same edge: the count reaches its last unit just as `req` drops. The bench provokes this by holding `req` for exactly N reference cycles and then dropping it. The judged outcome is that withdrawal wins: `proto_err` pulses, `ack` never rises, and the next full transaction completes with normal timing. Early withdrawals part-way through the count are checked the same way.

// File: rtl/alu_mdw_pkg.sv
// Package: operation codes and the delay-to-unit conversion shared by the
// wrapper. Assumes delays in picoseconds and a margin in whole percent.
package alu_mdw_pkg;

    localparam int OPW  = 3;
    localparam int NOPS = 8;

    typedef enum logic [OPW-1:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4,
        OP_MUL = 3'd5,
        OP_DIV = 3'd6,
        OP_RSV = 3'd7
    } alu_op_e;

    // Converts a critical path with margin into a rounded-up unit count.
    function automatic int unsigned dly_units(input int unsigned path_ps,
                                              input int unsigned unit_ps,
                                              input int unsigned margin_pct);
        int unsigned num;
        int unsigned den;
        int unsigned q;
        num = path_ps * (100 + margin_pct);
        den = 100 * unit_ps;
        q   = (num + den - 1) / den;
        return (q == 0) ? 1 : q;
    endfunction

    // Larger of two counts.
    function automatic int unsigned umax(input int unsigned x, input int unsigned y);
        return (x > y) ? x : y;
    endfunction

endpackage

// File: rtl/alu_core.sv
// alu_core: purely combinational ALU for the latched operation.
// Assumes its inputs are held stable by the handshake controller.
module alu_core
    import alu_mdw_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y
);
    localparam int PW = 2 * W;

    logic [PW-1:0] prod;

    // Full-width product, low half used below.
    always_comb prod = PW'(a) * PW'(b);

    // Operation select.
    always_comb begin
        case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_MUL:  y = prod[W-1:0];
            OP_DIV:  y = (b == '0) ? '1 : (a / b);
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/dly_table.sv
// dly_table: per-opcode lookup of matched-delay unit counts built from
// parameters. Assumes CW is wide enough for the largest count; unrecognised
// codes map to the largest entry.
module dly_table
    import alu_mdw_pkg::*;
#(
    parameter int unsigned UNIT_PS    = 100,
    parameter int unsigned MARGIN_PCT = 50,
    parameter int unsigned T_ADD_PS   = 1200,
    parameter int unsigned T_SUB_PS   = 1300,
    parameter int unsigned T_AND_PS   = 300,
    parameter int unsigned T_OR_PS    = 300,
    parameter int unsigned T_XOR_PS   = 400,
    parameter int unsigned T_MUL_PS   = 6000,
    parameter int unsigned T_DIV_PS   = 9000,
    parameter int          CW         = 8
) (
    input  alu_op_e        op,
    output logic [CW-1:0]  units
);
    localparam int unsigned U_ADD = dly_units(T_ADD_PS, UNIT_PS, MARGIN_PCT);
    localparam int unsigned U_SUB = dly_units(T_SUB_PS, UNIT_PS, MARGIN_PCT);
    localparam int unsigned U_AND = dly_units(T_AND_PS, UNIT_PS, MARGIN_PCT);
    localparam int unsigned U_OR  = dly_units(T_OR_PS,  UNIT_PS, MARGIN_PCT);
    localparam int unsigned U_XOR = dly_units(T_XOR_PS, UNIT_PS, MARGIN_PCT);
    localparam int unsigned U_MUL = dly_units(T_MUL_PS, UNIT_PS, MARGIN_PCT);
    localparam int unsigned U_DIV = dly_units(T_DIV_PS, UNIT_PS, MARGIN_PCT);
    localparam int unsigned U_MAX = umax(umax(umax(U_ADD, U_SUB), umax(U_AND, U_OR)),
                                         umax(umax(U_XOR, U_MUL), U_DIV));

    // Entry for a given code index.
    function automatic int unsigned pick(input int idx);
        case (idx)
            0:       return U_ADD;
            1:       return U_SUB;
            2:       return U_AND;
            3:       return U_OR;
            4:       return U_XOR;
            5:       return U_MUL;
            6:       return U_DIV;
            default: return U_MAX;
        endcase
    endfunction

    logic [CW-1:0] tab [NOPS];

    for (genvar g = 0; g < NOPS; g++) begin : g_tab
        assign tab[g] = CW'(pick(g));
    end

    // Table read by the live opcode.
    assign units = tab[op];
endmodule

// File: rtl/hs_ctrl.sv
// hs_ctrl: four-phase handshake sequencer with matched-delay countdown.
// Assumes req is synchronous to clk; latches op/operands on the starting edge.
module hs_ctrl
    import alu_mdw_pkg::*;
#(
    parameter int W  = 8,
    parameter int CW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req,
    input  alu_op_e        op_in,
    input  logic [W-1:0]   a_in,
    input  logic [W-1:0]   b_in,
    input  logic [CW-1:0]  units,
    output alu_op_e        op_q,
    output logic [W-1:0]   a_q,
    output logic [W-1:0]   b_q,
    output logic           ack,
    output logic           proto_err
);
    typedef enum logic [1:0] {S_IDLE, S_BUSY, S_DONE} hs_state_e;

    hs_state_e      state, state_nx;
    logic [CW-1:0]  cnt, cnt_nx;
    logic           start;

    assign start = (state == S_IDLE) && req;

    // Next state and countdown.
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        case (state)
            S_IDLE: if (req) begin
                state_nx = S_BUSY;
                cnt_nx   = units;
            end
            S_BUSY: if (!req) begin
                state_nx = S_IDLE;
            end else if (cnt <= CW'(1)) begin
                state_nx = S_DONE;
            end else begin
                cnt_nx = cnt - CW'(1);
            end
            S_DONE: if (!req) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // State, counter, acknowledge and error registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            cnt       <= '0;
            ack       <= 1'b0;
            proto_err <= 1'b0;
        end else begin
            state     <= state_nx;
            cnt       <= cnt_nx;
            ack       <= (state_nx == S_DONE);
            proto_err <= (state == S_BUSY) && !req;
        end
    end

    // Operand and opcode capture on the starting edge only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= OP_ADD;
            a_q  <= '0;
            b_q  <= '0;
        end else if (start) begin
            op_q <= op_in;
            a_q  <= a_in;
            b_q  <= b_in;
        end
    end
endmodule

// File: rtl/alu_mdw.sv
// alu_mdw: ALU with operation-matched completion acknowledge.
// Assumes clk period equals one unit delay and req is synchronous to clk.
module alu_mdw
    import alu_mdw_pkg::*;
#(
    parameter int          W          = 8,
    parameter int unsigned UNIT_PS    = 100,
    parameter int unsigned MARGIN_PCT = 50,
    parameter int unsigned T_ADD_PS   = 1200,
    parameter int unsigned T_SUB_PS   = 1300,
    parameter int unsigned T_AND_PS   = 300,
    parameter int unsigned T_OR_PS    = 300,
    parameter int unsigned T_XOR_PS   = 400,
    parameter int unsigned T_MUL_PS   = 6000,
    parameter int unsigned T_DIV_PS   = 9000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req,
    input  logic [2:0]     op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   result,
    output logic           ack,
    output logic           proto_err
);
    localparam int unsigned U_TOP = umax(umax(
        umax(dly_units(T_ADD_PS, UNIT_PS, MARGIN_PCT), dly_units(T_SUB_PS, UNIT_PS, MARGIN_PCT)),
        umax(dly_units(T_AND_PS, UNIT_PS, MARGIN_PCT), dly_units(T_OR_PS,  UNIT_PS, MARGIN_PCT))),
        umax(umax(dly_units(T_XOR_PS, UNIT_PS, MARGIN_PCT), dly_units(T_MUL_PS, UNIT_PS, MARGIN_PCT)),
             dly_units(T_DIV_PS, UNIT_PS, MARGIN_PCT)));
    localparam int CW = $clog2(U_TOP + 1);

    alu_op_e        op_live, op_q;
    logic [W-1:0]   a_q, b_q;
    logic [CW-1:0]  units;

    assign op_live = alu_op_e'(op);

    dly_table #(
        .UNIT_PS(UNIT_PS), .MARGIN_PCT(MARGIN_PCT),
        .T_ADD_PS(T_ADD_PS), .T_SUB_PS(T_SUB_PS), .T_AND_PS(T_AND_PS),
        .T_OR_PS(T_OR_PS), .T_XOR_PS(T_XOR_PS), .T_MUL_PS(T_MUL_PS),
        .T_DIV_PS(T_DIV_PS), .CW(CW)
    ) u_tab (
        .op    (op_live),
        .units (units)
    );

    hs_ctrl #(.W(W), .CW(CW)) u_hs (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .op_in     (op_live),
        .a_in      (a),
        .b_in      (b),
        .units     (units),
        .op_q      (op_q),
        .a_q       (a_q),
        .b_q       (b_q),
        .ack       (ack),
        .proto_err (proto_err)
    );

    alu_core #(.W(W)) u_alu (
        .op (op_q),
        .a  (a_q),
        .b  (b_q),
        .y  (result)
    );
endmodule

// File: rtl/alu_mdw_chk.sv
// alu_mdw_chk: handshake and output-stability properties, bound to alu_mdw.
module alu_mdw_chk #(
    parameter int W = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req,
    input logic          ack,
    input logic          proto_err,
    input logic [W-1:0]  result
);
    // R10: acknowledge only follows a sampled request.
    a_r10_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(req));

    // R8: acknowledge drops once request is seen low.
    a_r8_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !req) |=> !ack);

    // R7: result frozen while acknowledge is held.
    a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> (!ack || $stable(result)));

    // R9: error is a single-cycle pulse.
    a_r9_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> !proto_err);

    // R9: error and acknowledge never coincide.
    a_r9_err_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> !ack);

    // R3: a rising acknowledge means request was held for at least the start edge and one more.
    a_r3_ack_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> ($past(req) && $past(req, 2)));
endmodule

bind alu_mdw alu_mdw_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .ack       (ack),
    .proto_err (proto_err),
    .result    (result)
);

// File: tb/test_alu_mdw.sv
// Bench: sweeps every opcode over a grid of operands, then early-withdrawal cases.
module test_alu_mdw;
    localparam int W = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic [2:0]    op = '0;
    logic [W-1:0]  a = '0;
    logic [W-1:0]  b = '0;
    logic [W-1:0]  result;
    logic          ack;
    logic          proto_err;

    int n_chk = 0;
    int n_bad = 0;

    alu_mdw #(.W(W)) i_alu_mdw (
        .clk(clk), .rst_n(rst_n), .req(req), .op(op), .a(a), .b(b),
        .result(result), .ack(ack), .proto_err(proto_err)
    );

    always #5 clk = ~clk;

    // R2: delay figure per code, ps; code 7 takes the largest.
    function automatic int path_ps(input int code);
        case (code)
            0: return 1200; 1: return 1300; 2: return 300; 3: return 300;
            4: return 400;  5: return 6000; default: return 9000;
        endcase
    endfunction

    // R2: ceil(T*1.5/100) computed as ceil(3T/200).
    function automatic int exp_units(input int code);
        int t;
        t = path_ps(code);
        return (3 * t + 199) / 200;
    endfunction

    // R5: reference result.
    function automatic logic [W-1:0] exp_res(input int code, input logic [W-1:0] x,
                                             input logic [W-1:0] y);
        int p;
        case (code)
            0: return x + y;
            1: return x - y;
            2: return x & y;
            3: return x | y;
            4: return x ^ y;
            5: begin p = int'(x) * int'(y); return p[W-1:0]; end
            6: return (y == 0) ? {W{1'b1}} : x / y;
            default: return '0;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Full transaction; optionally disturbs inputs while timing (R6).
    task automatic txn(input int code, input logic [W-1:0] x, input logic [W-1:0] y,
                       input bit disturb);
        int lat;
        logic [W-1:0] held;
        @(negedge clk);
        op = code[2:0]; a = x; b = y; req = 1'b1;
        lat = 0;
        while (!ack && lat < 400) begin
            @(negedge clk);
            lat++;
            if (disturb && lat == 1) begin
                op = 3'(code + 1); a = ~x; b = y ^ 8'h01;
            end
        end
        // R3/R4: ack seen on falling edge N+1 after the start edge.
        check(lat == exp_units(code) + 1, code == 7 ? "R4 latency" : "R3 latency",
              lat, exp_units(code) + 1);
        check(result == exp_res(code, x, y), disturb ? "R6 result" : "R5 result",
              int'(result), int'(exp_res(code, x, y)));
        held = result;
        @(negedge clk);
        check(ack == 1'b1 && result == held, "R7 hold", int'(result), int'(held));
        req = 1'b0;
        @(negedge clk);
        check(ack == 1'b0, "R8 release", int'(ack), 0);
        check(result == held, "R7 after release", int'(result), int'(held));
    endtask

    // Withdraws request after 'hold' falling edges (R9).
    task automatic abort_txn(input int code, input int hold);
        @(negedge clk);
        op = code[2:0]; a = 8'h11; b = 8'h22; req = 1'b1;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            check(ack == 1'b0 && proto_err == 1'b0, "R9 no early ack", int'(ack), 0);
        end
        req = 1'b0;
        @(negedge clk);
        check(proto_err == 1'b1, "R9 error pulse", int'(proto_err), 1);
        check(ack == 1'b0, "R9 no ack", int'(ack), 0);
        @(negedge clk);
        check(proto_err == 1'b0, "R9 single cycle", int'(proto_err), 0);
        check(ack == 1'b0, "R10 idle ack", int'(ack), 0);
    endtask

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [W-1:0] grid [6];
        grid[0] = 8'h00; grid[1] = 8'h01; grid[2] = 8'h07;
        grid[3] = 8'h5a; grid[4] = 8'h80; grid[5] = 8'hff;

        repeat (3) @(negedge clk);
        check(ack == 1'b0 && proto_err == 1'b0, "R1 reset flags", int'(ack), 0);
        check(result == '0, "R1 reset result", int'(result), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ack == 1'b0 && result == '0, "R1 after release", int'(result), 0);

        for (int c = 0; c < 8; c++)
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++)
                    txn(c, grid[i], grid[j], 1'b0);

        // R6: inputs disturbed mid-count.
        for (int c = 0; c < 8; c++) txn(c, 8'h9c, 8'h0d, 1'b1);

        // R9: early withdrawal, and withdrawal on the expiry edge.
        abort_txn(0, 1);
        abort_txn(5, 40);
        for (int c = 0; c < 8; c++) abort_txn(c, exp_units(c));
        txn(1, 8'h30, 8'h31, 1'b0);
        txn(6, 8'hc8, 8'h00, 1'b0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule